// File: doc/BRIEF.md
# Serial Control and Status Port

This block is an 8-bit full-duplex serial control port of the kind used with MICROWIRE-style hosts. During each chip-select window the host clocks one byte into the block and, on the same clock edges, receives one status byte. The received byte becomes the control word of the line transceiver. That word holds the master/slave choice, the activate bit, four loopback selects, the mode of the D-channel clock pin and the B-channel swap. The returned status byte echoes the upper control bits and reports the live loop state.

The host pins (serial clock, active-low chip select, serial data in) are oversampled in the system clock domain. Each pin passes through a synchronizer and an edge detector before it reaches the shift engine, so every stored bit belongs to a single clock. The status inputs (loop in sync, line signal present, coding-violation pulse) come from logic in the same clock domain. The active-low interrupt output tells the host that the sync or line-signal state has changed.

The interface has no back-pressure. A byte is taken whenever the host completes eight clock pulses, and the host sets the pace of every access. No valid/ready pair is used because the serial link is host-paced and the status inputs are plain levels.

Top module: `serial_ctl_port`

## Requirements
- R1: Within one access, the bit on `sdi` is sampled on each rising `sclk` edge while `csn` is low, and `sdo` advances only on falling `sclk` edges. Only the first 8 rising edges of an access are used; any further edges are ignored.
- R2: Both directions shift the most significant bit first. The first rising edge captures control bit 7, and status bit 7 is the first bit presented on `sdo`.
- R3: Every access that receives 8 rising edges loads the received byte into `ctrl_word` when `csn` returns high. A host that only wants to read must therefore resend the current control word.
- R4: An access that ends with fewer than 8 rising edges leaves `ctrl_word` unchanged, and `ctrl_word` never changes while `csn` is low.
- R5: After reset, `ctrl_word` is 0x00 (master mode, not activated, no loopback, direct B channels), `sdo_oe` is 0 and `irq_n` is 1.
- R6: The status byte is captured when `csn` falls. Bits 7..3 hold `ctrl_word[7:3]`, bit 2 holds the violation flag, bit 1 holds `sync_ok` and bit 0 holds `line_sig`.
- R7: One or more `viol_pulse` cycles set the violation flag. The flag is cleared at each falling edge of `csn`, after the status byte has been captured, and a pulse in that same cycle keeps it set. A violation never changes `irq_n`.
- R8: Any change of `sync_ok` or `line_sig` drives `irq_n` low on the next cycle. Both are compared against their previous values, and those previous values are 0 just after reset.
- R9: `irq_n` returns high on the first rising `sclk` edge of an access and is not released by the falling edge of `csn` alone. A status change in the same cycle as that release keeps `irq_n` low.
- R10: `sdo_oe` is 0 while `csn` is high. It becomes 1, with status bit 7 already on `sdo`, as soon as the falling edge of `csn` is seen.
- R11: The decoded control outputs map to `ctrl_word` bits as follows: bit 0 `b_swap`, bit 1 `dchan_gate_mode`, bit 2 `loop_line_b2`, bit 3 `loop_line_b1`, bit 4 `loop_line_all`, bit 5 `loop_digital`, bit 6 `activate`, bit 7 `slave_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the host pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock |
| csn | input | 1 | Host chip select, active low |
| sdi | input | 1 | Serial control data from the host |
| sdo | output | 1 | Serial status data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| sync_ok | input | 1 | Loop in sync and activation complete |
| line_sig | input | 1 | Line signal present at the receiver |
| viol_pulse | input | 1 | One-cycle pulse per received coding violation |
| ctrl_word | output | 8 | Current control register |
| slave_mode | output | 1 | Slave end selected |
| activate | output | 1 | Power up and activate the loop |
| loop_digital | output | 1 | Loop back toward the digital interface |
| loop_line_all | output | 1 | Loop back both B channels and D toward the line |
| loop_line_b1 | output | 1 | Loop back B1 only toward the line |
| loop_line_b2 | output | 1 | Loop back B2 only toward the line |
| dchan_gate_mode | output | 1 | D-channel clock pin used as an enable instead of a clock |
| b_swap | output | 1 | Exchange B1 and B2 |
| irq_n | output | 1 | Latched interrupt, active low |

## Verification
A table of accesses writes control bytes with alternating and edge-heavy bit patterns (0xA5, 0x3C, 0xFF, 0x00, 0x81, 0x5A). This separates a correct MSB-first shift from a reversed or off-by-one one, and each returned byte shows whether the echo comes from the previous control word rather than the word being written. Across the table rows the status inputs rise and fall one at a time and together, and violation pulses land in some rows and not in others. This tells a correct sticky-then-clear flag from one that follows the pulse, and a change-triggered interrupt from a level-triggered one. Directed accesses then use 5, 11, 1 and 0 clock pulses to separate commit-on-complete from commit-on-any-access and from last-eight-bits capture. Further directed steps check that a violation alone leaves the interrupt released, and that the interrupt stays low through the falling edge of chip select until the first clock pulse.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  // Width of one serial transfer.
  localparam int unsigned WORD_W = 8;

  // Control word layout. The first field is bit 7, the first bit on the wire.
  typedef struct packed {
    logic slave;      // bit 7
    logic activate;   // bit 6
    logic loop_dig;   // bit 5
    logic loop_all;   // bit 4
    logic loop_b1;    // bit 3
    logic loop_b2;    // bit 2
    logic dgate;      // bit 1
    logic bswap;      // bit 0
  } ctrl_t;

  // Status word field positions.
  localparam int unsigned ST_LINE = 0;
  localparam int unsigned ST_SYNC = 1;
  localparam int unsigned ST_VIOL = 2;
  localparam int unsigned ST_ECHO = 3;  // lowest echoed control bit
  localparam int unsigned ECHO_W  = WORD_W - ST_ECHO;

  // Index of each host pin in the synchronizer vector.
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_CSN  = 1;
  localparam int unsigned PIN_SDI  = 2;
  localparam int unsigned PIN_N    = 3;

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    // chain[STAGES-1] is the synchronized level; chain[STAGES] is one cycle older.
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
      else        chain <= {chain[STAGES-1:0], din[g]};
    end

    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
  end

endmodule

// File: rtl/sp_shifter.sv
module sp_shifter
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,        // chip select asserted (synchronized)
  input  logic              start,      // chip select falling
  input  logic              stop,       // chip select rising
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              sdi_bit,
  input  logic [WORD_W-1:0] status_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              commit,     // complete access ends this cycle
  output logic              first_edge  // first rising serial edge of an access
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic              oe_q;
  logic              take;
  logic              advance;

  assign take    = act && !start && clk_rise && (cnt_q != FULL);
  assign advance = act && !start && clk_fall && (cnt_q != '0) && (cnt_q != FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else if (start) begin
      cnt_q <= '0;
      tx_q  <= status_word;
      rx_q  <= '0;
    end else begin
      if (take) begin
        rx_q  <= {rx_q[WORD_W-2:0], sdi_bit};
        cnt_q <= cnt_q + 1'b1;
      end
      if (advance) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oe_q <= 1'b0;
    else if (start) oe_q <= 1'b1;
    else if (stop)  oe_q <= 1'b0;
  end

  assign sdo        = tx_q[WORD_W-1];
  assign sdo_oe     = oe_q;
  assign rx_word    = rx_q;
  assign commit     = stop && (cnt_q == FULL);
  assign first_edge = act && !start && clk_rise && (cnt_q == '0);

  // R2: the first captured bit lands in the lowest position and moves up later.
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    first_edge |=> rx_q[0] == $past(sdi_bit));

  // R1: the received byte holds still except on a rising serial edge or a new access.
  assert_rx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_rise && !start) |=> $stable(rx_q));

  // R10: the output driver turns off once chip select has risen.
  assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !sdo_oe);

  // R6: the word presented at the start of an access is the status word of that cycle.
  assert_status_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sdo == $past(status_word[WORD_W-1]));

endmodule

// File: rtl/sp_status.sv
module sp_status
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ECHO_W-1:0] ctrl_echo,
  input  logic              sync_ok,
  input  logic              line_sig,
  input  logic              viol_pulse,
  input  logic              access_start,
  input  logic              first_edge,
  output logic [WORD_W-1:0] status_word,
  output logic              irq_n
);

  logic viol_q;
  logic sync_prev_q;
  logic line_prev_q;
  logic irq_q;
  logic changed;

  assign changed = (sync_ok != sync_prev_q) || (line_sig != line_prev_q);

  // Sticky violation flag: a new pulse wins over the clear from chip select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            viol_q <= 1'b0;
    else if (viol_pulse)   viol_q <= 1'b1;
    else if (access_start) viol_q <= 1'b0;
  end

  // Interrupt latch: a status change wins over the release by the first clock pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev_q <= 1'b0;
      line_prev_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      sync_prev_q <= sync_ok;
      line_prev_q <= line_sig;
      if (changed)         irq_q <= 1'b1;
      else if (first_edge) irq_q <= 1'b0;
    end
  end

  always_comb begin
    status_word                         = '0;
    status_word[WORD_W-1:ST_ECHO]       = ctrl_echo;
    status_word[ST_VIOL]                = viol_q;
    status_word[ST_SYNC]                = sync_ok;
    status_word[ST_LINE]                = line_sig;
  end

  assign irq_n = ~irq_q;

  // R7: a violation pulse always leaves the flag set in the next cycle.
  assert_viol_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> status_word[ST_VIOL]);

  // R7: a violation alone never pulls the interrupt low.
  assert_viol_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && viol_pulse && irq_n && $stable(sync_ok) && $stable(line_sig))
      |=> irq_n);

  // R8: a change on either status input pulls the interrupt low.
  assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (!$stable(sync_ok) || !$stable(line_sig))) |=> !irq_n);

  // R9: the interrupt is only released by the first clock pulse of an access.
  assert_irq_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(first_edge));

endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
  import sctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       csn,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       sync_ok,
  input  logic       line_sig,
  input  logic       viol_pulse,
  output logic [7:0] ctrl_word,
  output logic       slave_mode,
  output logic       activate,
  output logic       loop_digital,
  output logic       loop_line_all,
  output logic       loop_line_b1,
  output logic       loop_line_b2,
  output logic       dchan_gate_mode,
  output logic       b_swap,
  output logic       irq_n
);

  localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1) << PIN_CSN;

  logic [PIN_N-1:0]  pins;
  logic [PIN_N-1:0]  pin_lvl;
  logic [PIN_N-1:0]  pin_rise;
  logic [PIN_N-1:0]  pin_fall;
  logic              cs_act;
  logic              cs_start;
  logic              cs_stop;
  logic [WORD_W-1:0] status_word;
  logic [WORD_W-1:0] rx_word;
  logic              commit;
  logic              first_edge;
  ctrl_t             ctrl_q;

  always_comb begin
    pins           = '0;
    pins[PIN_SCLK] = sclk;
    pins[PIN_CSN]  = csn;
    pins[PIN_SDI]  = sdi;
  end

  sp_sync_edge #(
    .N      (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign cs_act   = ~pin_lvl[PIN_CSN];
  assign cs_start = pin_fall[PIN_CSN];
  assign cs_stop  = pin_rise[PIN_CSN];

  sp_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (cs_act),
    .start      (cs_start),
    .stop       (cs_stop),
    .clk_rise   (pin_rise[PIN_SCLK]),
    .clk_fall   (pin_fall[PIN_SCLK]),
    .sdi_bit    (pin_lvl[PIN_SDI]),
    .status_word(status_word),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .rx_word    (rx_word),
    .commit     (commit),
    .first_edge (first_edge)
  );

  sp_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_echo   (ctrl_q[WORD_W-1:ST_ECHO]),
    .sync_ok     (sync_ok),
    .line_sig    (line_sig),
    .viol_pulse  (viol_pulse),
    .access_start(cs_start),
    .first_edge  (first_edge),
    .status_word (status_word),
    .irq_n       (irq_n)
  );

  // Control register: loaded only when a complete access ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (commit) ctrl_q <= ctrl_t'(rx_word);
  end

  assign ctrl_word       = ctrl_q;
  assign slave_mode      = ctrl_q.slave;
  assign activate        = ctrl_q.activate;
  assign loop_digital    = ctrl_q.loop_dig;
  assign loop_line_all   = ctrl_q.loop_all;
  assign loop_line_b1    = ctrl_q.loop_b1;
  assign loop_line_b2    = ctrl_q.loop_b2;
  assign dchan_gate_mode = ctrl_q.dgate;
  assign b_swap          = ctrl_q.bswap;

  // R4: the control word cannot move in the middle of an access.
  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act)) |-> $stable(ctrl_q));

  // R3: a change of the control word happens only just after chip select rises.
  assert_ctrl_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(ctrl_q)) |-> $past(cs_stop));

endmodule

// File: tb/sim_serial_ctl_port.sv
module sim_serial_ctl_port;

  localparam int HALF = 8;  // system cycles per serial half-period
  // Row layout: {control byte to write, sync_ok, line_sig, violation pulse before access}
  localparam logic [10:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b0, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b1, 1'b0},
    {8'h81, 1'b0, 1'b1, 1'b1},
    {8'h5A, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic sdi = 1'b0;
  logic sync_ok = 1'b0;
  logic line_sig = 1'b0;
  logic viol_pulse = 1'b0;
  logic sdo, sdo_oe, irq_n;
  logic [7:0] ctrl_word;
  logic slave_mode, activate, loop_digital, loop_line_all;
  logic loop_line_b1, loop_line_b2, dchan_gate_mode, b_swap;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_ctrl = 8'h00;
  logic       m_viol = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  serial_ctl_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .sync_ok(sync_ok), .line_sig(line_sig),
    .viol_pulse(viol_pulse), .ctrl_word(ctrl_word), .slave_mode(slave_mode),
    .activate(activate), .loop_digital(loop_digital), .loop_line_all(loop_line_all),
    .loop_line_b1(loop_line_b1), .loop_line_b2(loop_line_b2),
    .dchan_gate_mode(dchan_gate_mode), .b_swap(b_swap), .irq_n(irq_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_viol();
    viol_pulse = 1'b1; tick(1); viol_pulse = 1'b0;
    m_viol = 1'b1;
  endtask

  task automatic access(input logic [7:0] wr, input int nclk, output logic [7:0] rd);
    rd = '0;
    csn = 1'b0; tick(8);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 8) ? wr[7-i] : 1'b1;
      tick(HALF);
      if (i < 8) rd[7-i] = sdo;
      sclk = 1'b1; tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    csn = 1'b1; tick(8);
    m_viol = 1'b0;
    if (nclk >= 8) m_ctrl = wr;
  endtask

  function automatic logic [7:0] decoded();
    return {slave_mode, activate, loop_digital, loop_line_all,
            loop_line_b1, loop_line_b2, dchan_gate_mode, b_swap};
  endfunction

  initial begin
    logic [7:0] rd;
    logic [7:0] exp_rd;
    logic       chg;
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // R5: reset state
    chk("R5 ctrl_word", ctrl_word, 8'h00);
    chk("R5 sdo_oe", sdo_oe, 1'b0);
    chk("R5 irq_n", irq_n, 1'b1);
    chk("R11 decoded after reset", decoded(), 8'h00);

    // Table walk
    for (int k = 0; k < 6; k++) begin
      chg = (VEC[k][2] != sync_ok) || (VEC[k][1] != line_sig);
      sync_ok = VEC[k][2];
      line_sig = VEC[k][1];
      tick(1);
      if (VEC[k][0]) pulse_viol();
      tick(6);
      chk("R8 irq_n before access", irq_n, chg ? 1'b0 : 1'b1);
      exp_rd = {m_ctrl[7:3], m_viol, sync_ok, line_sig};
      access(VEC[k][10:3], 8, rd);
      chk("R6 R2 status byte", rd, exp_rd);
      chk("R9 irq_n after access", irq_n, 1'b1);
      chk("R3 ctrl_word", ctrl_word, VEC[k][10:3]);
      chk("R11 decoded outputs", decoded(), VEC[k][10:3]);
    end

    // R4: short access is discarded
    access(8'h12, 5, rd);
    chk("R4 short access keeps ctrl", ctrl_word, m_ctrl);

    // R1: extra clocks beyond eight are ignored
    access(8'hC3, 11, rd);
    chk("R1 first eight bits kept", ctrl_word, 8'hC3);

    // R10: output enable follows chip select
    chk("R10 oe idle", sdo_oe, 1'b0);
    csn = 1'b0; tick(8);
    chk("R10 oe active", sdo_oe, 1'b1);
    chk("R10 first bit driven", sdo, m_ctrl[7]);
    csn = 1'b1; tick(8);
    m_viol = 1'b0;
    chk("R10 oe released", sdo_oe, 1'b0);
    chk("R4 zero-clock access keeps ctrl", ctrl_word, 8'hC3);

    // R7: violation is sticky, raises no interrupt, cleared by next chip select
    pulse_viol();
    tick(6);
    chk("R7 no irq on violation", irq_n, 1'b1);
    access(m_ctrl, 8, rd);
    chk("R7 violation reported", rd, {8'hC3 & 8'hF8} | 8'h04);
    access(m_ctrl, 8, rd);
    chk("R7 violation cleared", rd[2], 1'b0);

    // R9: release only on first clock pulse, not on chip select fall
    line_sig = 1'b1;
    tick(6);
    chk("R8 irq on line change", irq_n, 1'b0);
    csn = 1'b0; tick(8);
    chk("R9 irq held through cs fall", irq_n, 1'b0);
    sdi = 1'b0; tick(HALF);
    sclk = 1'b1; tick(HALF);
    chk("R9 irq released by first clock", irq_n, 1'b1);
    sclk = 1'b0; tick(HALF);
    csn = 1'b1; tick(8);
    chk("R4 one-clock access keeps ctrl", ctrl_word, 8'hC3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule